// File: doc/BRIEF.md
# Sixteen-bit registered word shifter

The block shifts a 16-bit word left, logically right or arithmetically right by a count taken from a port. It produces the shifted word and the arithmetic flags (carry, overflow, sign, zero, parity, auxiliary carry) one clock after the request is presented. It is meant to sit in an execution pipeline. The caller writes the result back and merges the flags only when the update-enable output is high.

Only the low five bits of the count take part. A masked count of zero, or the unused operation code, turns the request into a no-operation: the word is passed through unchanged, update-enable stays low and the flag outputs keep their earlier values. The carry and overflow outputs are defined for every masked count from 1 to 31, including left shifts that push the whole word out and right arithmetic shifts that leave only sign copies.

Top module: `word_shifter`

## Requirements
- R1: Only count bits [4:0] are used; bits [7:5] have no effect on any output.
- R2: A request whose masked count is zero returns the operand unchanged on `res_q`, drives `upd_en` low and leaves all six flag outputs at their previous values.
- R3: Left shift (`op_sel` = 00) by 1..16 gives the operand shifted left with zero fill, carry = operand bit (16 - count), overflow = carry XOR result bit 15.
- R4: Left shift by 17..31 gives a zero result with carry and overflow both zero.
- R5: Logical right shift (`op_sel` = 01) fills with zeros; carry = operand bit (count - 1) for counts up to 16, else zero; overflow = result bit 15 XOR result bit 14, so it is the original top bit for count 1 and zero for larger counts.
- R6: Arithmetic right shift (`op_sel` = 10) fills with the operand's bit 15; carry = bit (count - 1) of the sign-extended operand, so counts of 17 and above give the sign; overflow is always zero.
- R7: On every update, sign = result bit 15, zero = 1 when the result is all zeros, parity = 1 when the low result byte has an even number of ones, and auxiliary carry = 0.
- R8: Operation code 11 is a no-operation: result = operand, `upd_en` low, flags held.
- R9: `out_valid` equals `in_valid` delayed by one clock; after an idle cycle `upd_en` is low and `res_q` holds its value.
- R10: Synchronous reset, active high, clears `out_valid`, `upd_en`, `res_q` and all flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 no-op |
| opnd | input | 16 | Operand word |
| cnt | input | 8 | Shift count, low five bits used |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| upd_en | output | 1 | Write back the result and merge the flags |
| res_q | output | 16 | Result word |
| cf_q | output | 1 | Carry |
| of_q | output | 1 | Overflow |
| sf_q | output | 1 | Sign |
| zf_q | output | 1 | Zero |
| pf_q | output | 1 | Even parity of the low result byte |
| af_q | output | 1 | Auxiliary carry, always zero on update |

## Verification
Every piece of state is an output register, so a wrong value shows on the ports in the cycle right after the request that caused it. A register that loads when it should hold shows one cycle later instead. A flag that changes on a zero-count or no-op request is caught at that request. Leftover state after an idle cycle is caught at the next idle response. Carry taken from the wrong end, or the wrong fill bit at count 16 or 17, affects only a few counts. The directed cases aim at those counts, and the random sweep covers the rest.

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd,
  input  logic [7:0]   cnt,
  output logic         out_valid,
  output logic         upd_en,
  output logic [W-1:0] res_q,
  output logic         cf_q,
  output logic         of_q,
  output logic         sf_q,
  output logic         zf_q,
  output logic         pf_q,
  output logic         af_q
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [1:0] OP_SHL = 2'b00;
  localparam logic [1:0] OP_SHR = 2'b01;
  localparam logic [1:0] OP_SAR = 2'b10;

  logic [CW-1:0]  amt;
  logic [2*W-1:0] shl_x, shr_x, sar_x;
  logic [W-1:0]   n_res;
  logic           n_cf, n_of, active;

  assign amt   = cnt[CW-1:0];
  assign shl_x = {{W{1'b0}}, opnd} << amt;
  assign shr_x = {opnd, {W{1'b0}}} >> amt;
  assign sar_x = $signed({opnd, {W{1'b0}}}) >>> amt;

  assign active = in_valid && (op_sel != 2'b11) && (amt != '0);

  always_comb begin
    n_res = opnd;
    n_cf  = 1'b0;
    n_of  = 1'b0;
    case (op_sel)
      OP_SHL: begin
        n_res = shl_x[W-1:0];
        n_cf  = shl_x[W];
        n_of  = shl_x[W] ^ shl_x[W-1];
      end
      OP_SHR: begin
        n_res = shr_x[2*W-1:W];
        n_cf  = shr_x[W-1];
        n_of  = shr_x[2*W-1] ^ shr_x[2*W-2];
      end
      OP_SAR: begin
        n_res = sar_x[2*W-1:W];
        n_cf  = sar_x[W-1];
        n_of  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      upd_en    <= 1'b0;
      res_q     <= '0;
      cf_q      <= 1'b0;
      of_q      <= 1'b0;
      sf_q      <= 1'b0;
      zf_q      <= 1'b0;
      pf_q      <= 1'b0;
      af_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      upd_en    <= active;
      if (in_valid) res_q <= active ? n_res : opnd;
      if (active) begin
        cf_q <= n_cf;
        of_q <= n_of;
        sf_q <= n_res[W-1];
        zf_q <= (n_res == '0);
        pf_q <= ~^n_res[7:0];
        af_q <= 1'b0;
      end
    end
  end
endmodule

module word_shifter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   op_sel,
  input logic [W-1:0] opnd,
  input logic [7:0]   cnt,
  input logic         out_valid,
  input logic         upd_en,
  input logic [W-1:0] res_q,
  input logic         cf_q,
  input logic         of_q,
  input logic         sf_q,
  input logic         zf_q,
  input logic         pf_q,
  input logic         af_q
);
  localparam int CW = $clog2(W) + 1;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !upd_en && $stable(res_q)));
  a_r8_nop_passes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> (!upd_en && res_q == $past(opnd)));
  a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt[CW-1:0] == '0) |=>
      (!upd_en && res_q == $past(opnd) && $stable({cf_q, of_q, sf_q, zf_q, pf_q, af_q})));
  a_r6_sar_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b10 && cnt[CW-1:0] != '0) |=> (upd_en && !of_q));
  a_r4_left_flush: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && cnt[CW-1:0] > W) |=> (res_q == '0 && !cf_q && !of_q));
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (zf_q == (res_q == '0) && sf_q == res_q[W-1]));
  a_r9_upd_needs_valid: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> out_valid);
endmodule

bind word_shifter word_shifter_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .opnd(opnd), .cnt(cnt),
  .out_valid(out_valid), .upd_en(upd_en), .res_q(res_q), .cf_q(cf_q), .of_q(of_q),
  .sf_q(sf_q), .zf_q(zf_q), .pf_q(pf_q), .af_q(af_q)
);

// File: tb/word_shifter_tb_top.sv
`timescale 1ns/100ps
module word_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [15:0] opnd = '0;
  logic [7:0]  cnt = '0;
  logic        out_valid, upd_en, cf_q, of_q, sf_q, zf_q, pf_q, af_q;
  logic [15:0] res_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0]  hold_flags = '0;
  logic [15:0] last_res = '0;

  always #2.5 clk = ~clk;

  word_shifter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .opnd(opnd), .cnt(cnt),
    .out_valid(out_valid), .upd_en(upd_en), .res_q(res_q), .cf_q(cf_q), .of_q(of_q),
    .sf_q(sf_q), .zf_q(zf_q), .pf_q(pf_q), .af_q(af_q)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [15:0] a, input logic [7:0] c, input string tag);
    int m;
    logic [15:0] e_res;
    logic e_cf, e_of, e_upd;
    int ones;
    m = c & 31;
    e_res = a; e_cf = 0; e_of = 0;
    e_upd = (op != 2'b11) && (m != 0);
    if (e_upd) begin
      for (int i = 0; i < 16; i++) begin
        if (op == 2'b00)      e_res[i] = (i - m >= 0) ? a[i-m] : 1'b0;
        else if (op == 2'b01) e_res[i] = (i + m <= 15) ? a[i+m] : 1'b0;
        else                  e_res[i] = (i + m <= 15) ? a[i+m] : a[15];
      end
      if (op == 2'b00) begin
        e_cf = (m <= 16) ? a[16-m] : 1'b0;
        e_of = e_cf ^ e_res[15];
      end else if (op == 2'b01) begin
        e_cf = (m <= 16) ? a[m-1] : 1'b0;
        e_of = e_res[15] ^ e_res[14];
      end else begin
        e_cf = (m <= 16) ? a[m-1] : a[15];
        e_of = 1'b0;
      end
      ones = 0;
      for (int i = 0; i < 8; i++) ones += e_res[i];
      hold_flags = {e_cf, e_of, e_res[15], (e_res == 16'h0), (ones % 2 == 0), 1'b0};
    end
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd = a; cnt = c;
    @(negedge clk);
    in_valid = 1'b0;
    last_res = e_res;
    check(out_valid === 1'b1, {tag, " R9 valid"}, {31'b0, out_valid}, 32'd1);
    check(upd_en === e_upd, {tag, " upd"}, {31'b0, upd_en}, {31'b0, e_upd});
    check(res_q === e_res, {tag, " result"}, {16'b0, res_q}, {16'b0, e_res});
    check({cf_q, of_q, sf_q, zf_q, pf_q, af_q} === hold_flags, {tag, " R7 flags"},
          {26'b0, cf_q, of_q, sf_q, zf_q, pf_q, af_q}, {26'b0, hold_flags});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(out_valid === 1'b0 && upd_en === 1'b0, "R9 idle strobes", {30'b0, out_valid, upd_en}, 32'd0);
    check(res_q === last_res, "R9 idle hold", {16'b0, res_q}, {16'b0, last_res});
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_0017);
    repeat (3) @(negedge clk);
    check({out_valid, upd_en, cf_q, of_q, sf_q, zf_q, pf_q, af_q} === 8'h00 && res_q === 16'h0,
          "R10 reset", {15'b0, out_valid, upd_en, res_q}, 32'd0);
    rst = 1'b0;
    apply(2'b00, 16'h8001, 8'd1,  "R3 shl1");
    apply(2'b00, 16'h0001, 8'd16, "R3 shl16");
    apply(2'b00, 16'h4321, 8'd15, "R3 shl15");
    apply(2'b00, 16'hFFFF, 8'd17, "R4 shl17");
    apply(2'b00, 16'hFFFF, 8'd31, "R4 shl31");
    apply(2'b01, 16'h8001, 8'd1,  "R5 shr1");
    apply(2'b01, 16'hC000, 8'd2,  "R5 shr2");
    apply(2'b01, 16'h8000, 8'd16, "R5 shr16");
    apply(2'b01, 16'hFFFF, 8'd17, "R5 shr17");
    apply(2'b10, 16'h8000, 8'd16, "R6 sar16");
    apply(2'b10, 16'h8000, 8'd31, "R6 sar31");
    apply(2'b10, 16'h7FFF, 8'd20, "R6 sar20pos");
    apply(2'b10, 16'hA5A5, 8'd4,  "R6 sar4");
    apply(2'b00, 16'h1234, 8'h20, "R2 R1 masked zero");
    apply(2'b01, 16'hF0F0, 8'h00, "R2 zero");
    apply(2'b01, 16'hF0F0, 8'hE3, "R1 high bits");
    apply(2'b11, 16'hBEEF, 8'd5,  "R8 nop");
    idle_check();
    apply(2'b00, 16'h0080, 8'd8,  "R7 zero low byte");
    idle_check();
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      apply(op, 16'($urandom), 8'($urandom), "R3 R5 R6 R7 random");
      if ($urandom_range(0, 7) == 0) idle_check();
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({out_valid, upd_en} === 2'b00 && res_q === 16'h0, "R10 late reset",
          {14'b0, out_valid, upd_en, res_q}, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule